// File: doc/BRIEF.md
# Shared-Bus Latched Seven-Segment Writer

This block writes hexadecimal values into a row of common-anode seven-segment digits. All digits share one 7-bit segment bus, and each digit sits behind its own transparent latch with a separate active-high enable. A single write strobe takes a snapshot of every digit's 4-bit value. The block then visits the digits in ascending order. For each digit it drives the decoded active-low pattern onto the bus, pulses only that digit's enable, and then holds the bus for one more clock so that the latch closes on settled data.

Once the sequence ends, the latches keep the patterns and the block goes idle. There is no refresh scan. A busy flag covers the whole sequence, and any strobe that arrives while busy is dropped. The enable pulse width and the number of digits are parameters.

Top module: `seg_latch_writer`

## Requirements
- R1: After reset all latch enables are low, `seg_o` is 7'h7F (all segments dark) and `busy_o` is low.
- R2: Segment bit 0 is A through bit 6 is G, and a lit segment is driven 0. Values 0..F decode to the active-high patterns 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex), and the bus carries the inverse of each.
- R3: The bus carries a digit's pattern for exactly one clock before its enable rises. The bus does not change while the enable is high. It keeps the same value for exactly one clock after the enable falls.
- R4: At most one enable is high in any cycle. Digit 0 is written first, then digit 1 and so on upward.
- R5: Each enable stays high for exactly PULSE_LEN consecutive clocks (default 2).
- R6: A strobe sampled high while idle raises `busy_o` in the next cycle. `busy_o` then stays high for NUM_DIGITS*(PULSE_LEN+2) cycles. A strobe sampled while busy is ignored.
- R7: Digit d takes its value from `val_i[4d+3:4d]` as sampled on the accepted strobe edge. Changes to `val_i` while busy have no effect.
- R8: When a sequence completes, each external latch holds the decoded pattern of its digit's captured value. After the sequence the bus keeps the last digit's pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe |
| val_i | input | NUM_DIGITS*4 | Hex value per digit, digit d at bits 4d+3:4d |
| seg_o | output | 7 | Shared active-low segment bus, bit 0 = A |
| le_o | output | NUM_DIGITS | Per-digit latch enable, active high |
| busy_o | output | 1 | Sequence in progress |

## Verification
Some properties are checked on every cycle: enable exclusivity, bus stability on the cycle an enable rises and on the cycle it falls, the pulse width, and that an enable is high only while busy. Only the bench scenarios can show that the right pattern reaches the right latch. The same holds for the value snapshot at the strobe, the dropping of strobes while busy, and the complete hex table. The bench shows these by comparing against a cycle model and against behavioural latches.

// File: rtl/seg_latch_pkg.sv
package seg_latch_pkg;
  localparam int SEG_W = 7;
  localparam int HEX_W = 4;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_HOLD  = 2'd3
  } wr_state_e;
endpackage

// File: rtl/hex_seg_decode.sv
module hex_seg_decode
  import seg_latch_pkg::*;
(
  input  logic [HEX_W-1:0] hex_i,
  output logic [SEG_W-1:0] seg_n_o
);
  logic [SEG_W-1:0] seg_on;

  always_comb begin
    unique case (hex_i)
      4'h0: seg_on = 7'h3F;
      4'h1: seg_on = 7'h06;
      4'h2: seg_on = 7'h5B;
      4'h3: seg_on = 7'h4F;
      4'h4: seg_on = 7'h66;
      4'h5: seg_on = 7'h6D;
      4'h6: seg_on = 7'h7D;
      4'h7: seg_on = 7'h07;
      4'h8: seg_on = 7'h7F;
      4'h9: seg_on = 7'h6F;
      4'hA: seg_on = 7'h77;
      4'hB: seg_on = 7'h7C;
      4'hC: seg_on = 7'h39;
      4'hD: seg_on = 7'h5E;
      4'hE: seg_on = 7'h79;
      default: seg_on = 7'h71;
    endcase
  end

  // common anode: lit segment is low
  assign seg_n_o = ~seg_on;
endmodule

// File: rtl/seg_write_seq.sv
module seg_write_seq
  import seg_latch_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  parameter int PULSE_LEN  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [NUM_DIGITS*HEX_W-1:0] val_i,
  output logic [SEG_W-1:0]            seg_o,
  output logic [NUM_DIGITS-1:0]       le_o,
  output logic                        busy_o
);
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PULSE_LEN - 1);

  wr_state_e                   state_q;
  logic [IDX_W-1:0]            idx_q, nxt_idx;
  logic [CNT_W-1:0]            cnt_q;
  logic [NUM_DIGITS*HEX_W-1:0] vals_q;
  logic [SEG_W-1:0]            seg_q;
  logic [NUM_DIGITS-1:0]       le_q;
  logic [SEG_W-1:0]            pat_first;
  logic [SEG_W-1:0]            pat_q [NUM_DIGITS];

  // first digit decodes straight from the input so setup starts on the strobe edge
  hex_seg_decode u_dec_first (
    .hex_i   (val_i[HEX_W-1:0]),
    .seg_n_o (pat_first)
  );

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dec
    hex_seg_decode u_dec (
      .hex_i   (vals_q[d*HEX_W +: HEX_W]),
      .seg_n_o (pat_q[d])
    );
  end

  assign nxt_idx = idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      vals_q  <= '0;
      seg_q   <= '1;
      le_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_i) begin
            vals_q  <= val_i;
            idx_q   <= '0;
            seg_q   <= pat_first;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          le_q        <= '0;
          le_q[idx_q] <= 1'b1;
          cnt_q       <= '0;
          state_q     <= ST_PULSE;
        end
        ST_PULSE: begin
          if (cnt_q == LAST_CNT) begin
            le_q    <= '0;
            state_q <= ST_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= nxt_idx;
            seg_q   <= pat_q[nxt_idx];
            state_q <= ST_SETUP;
          end
        end
      endcase
    end
  end

  assign seg_o  = seg_q;
  assign le_o   = le_q;
  assign busy_o = (state_q != ST_IDLE);

  AST_LE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(le_q)); // R4
  AST_LE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|le_q) |-> busy_o); // R6

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_ast
    AST_SETUP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(le_q[d]) |-> $stable(seg_q)); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(le_q[d]) |-> $stable(seg_q)); // R3
    AST_BUS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (le_q[d] && $past(le_q[d])) |-> $stable(seg_q)); // R3
  end
endmodule

// File: rtl/seg_latch_writer.sv
module seg_latch_writer
  import seg_latch_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  parameter int PULSE_LEN  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [NUM_DIGITS*HEX_W-1:0] val_i,
  output logic [SEG_W-1:0]            seg_o,
  output logic [NUM_DIGITS-1:0]       le_o,
  output logic                        busy_o
);
  localparam int HI_W = $clog2(PULSE_LEN + 2);

  seg_write_seq #(
    .NUM_DIGITS (NUM_DIGITS),
    .PULSE_LEN  (PULSE_LEN)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .val_i  (val_i),
    .seg_o  (seg_o),
    .le_o   (le_o),
    .busy_o (busy_o)
  );

  // independent pulse-width counter for the width check
  logic [HI_W-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   hi_cnt_q <= '0;
    else if (!(|le_o))                             hi_cnt_q <= '0;
    else if (hi_cnt_q != HI_W'(PULSE_LEN + 1))     hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|le_o) |-> (hi_cnt_q == HI_W'(PULSE_LEN))); // R5
  AST_PULSE_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt_q <= HI_W'(PULSE_LEN)); // R5
endmodule

// File: tb/tb_seg_latch_writer.sv
`timescale 1ns/1ps
module tb_seg_latch_writer;
  localparam int N = 2;
  localparam int P = 2;
  localparam int SEQ = N * (P + 2);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0;
  logic [N*4-1:0] val = '0;
  logic [6:0]   seg;
  logic [N-1:0] le;
  logic         busy;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_latch_writer #(.NUM_DIGITS(N), .PULSE_LEN(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .val_i(val),
    .seg_o(seg), .le_o(le), .busy_o(busy)
  );

  // behavioural external latches
  logic [6:0] disp [N];
  always @(*) if (le[0]) disp[0] = seg;
  always @(*) if (le[1]) disp[1] = seg;

  function automatic logic [6:0] exp_pat(input logic [3:0] h);
    logic [6:0] on;
    case (h)
      4'h0: on = 7'h3F; 4'h1: on = 7'h06; 4'h2: on = 7'h5B; 4'h3: on = 7'h4F;
      4'h4: on = 7'h66; 4'h5: on = 7'h6D; 4'h6: on = 7'h7D; 4'h7: on = 7'h07;
      4'h8: on = 7'h7F; 4'h9: on = 7'h6F; 4'hA: on = 7'h77; 4'hB: on = 7'h7C;
      4'hC: on = 7'h39; 4'hD: on = 7'h5E; 4'hE: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  // cycle reference model
  bit         m_busy;
  int         m_t;
  logic [3:0] m_val [N];
  logic [6:0] m_last;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_t = 0; m_last = 7'h7F;
    end else if (m_busy) begin
      if (m_t == SEQ - 1) m_busy = 1'b0;
      else m_t++;
    end else if (wr) begin
      m_busy = 1'b1; m_t = 0;
      for (int d = 0; d < N; d++) m_val[d] = val[d*4 +: 4];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [6:0] e_seg;
      logic [N-1:0] e_le;
      e_le = '0;
      if (m_busy) begin
        int d, l;
        d = m_t / (P + 2);
        l = m_t % (P + 2);
        e_seg = exp_pat(m_val[d]);
        m_last = e_seg;
        if (l >= 1 && l <= P) e_le[d] = 1'b1;
      end else begin
        e_seg = m_last;
      end
      check("R2/R3 seg", 32'(seg), 32'(e_seg));
      check("R4/R5 le", 32'(le), 32'(e_le));
      check("R6 busy", 32'(busy), 32'(m_busy));
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic write(input logic [3:0] v0, input logic [3:0] v1);
    @(negedge clk);
    val = {v1, v0};
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    wait_idle();
  endtask

  task automatic check_disp(input string tag, input logic [3:0] v0, input logic [3:0] v1);
    check({tag, " d0"}, 32'(disp[0]), 32'(exp_pat(v0)));
    check({tag, " d1"}, 32'(disp[1]), 32'(exp_pat(v1)));
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 seg", 32'(seg), 32'h7F);
    check("R1 le", 32'(le), 32'h0);
    check("R1 busy", 32'(busy), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    write(4'h3, 4'hA);
    check_disp("R8 basic", 4'h3, 4'hA);

    // R2 full table across both digits
    for (int i = 0; i < 16; i++) begin
      write(4'(i), 4'(15 - i));
      check_disp("R2 table", 4'(i), 4'(15 - i));
    end

    // R7 input change while busy
    @(negedge clk);
    val = {4'h5, 4'h9}; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; val = {4'hE, 4'h1};
    wait_idle();
    check_disp("R7 snapshot", 4'h9, 4'h5);

    // R6 strobe while busy ignored
    @(negedge clk);
    val = {4'h2, 4'h7}; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    repeat (2) @(negedge clk);
    val = {4'hC, 4'hB}; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    wait_idle();
    check_disp("R6 ignored", 4'h7, 4'h2);
    repeat (3) @(negedge clk);
    check("R6 stays idle", 32'(busy), 32'h0);

    // R6 strobe held high: back-to-back sequences
    @(negedge clk);
    val = {4'hF, 4'h0}; wr = 1'b1;
    repeat (3 * SEQ) @(negedge clk);
    wr = 1'b0;
    wait_idle();
    check_disp("R6 held strobe", 4'h0, 4'hF);

    // R1 asynchronous reset mid-sequence
    @(negedge clk);
    val = {4'h4, 4'h8}; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R1 reset seg", 32'(seg), 32'h7F);
    check("R1 reset le", 32'(le), 32'h0);
    check("R1 reset busy", 32'(busy), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    write(4'h6, 4'hD);
    check_disp("R8 after reset", 4'h6, 4'hD);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule